// File: doc/BRIEF.md
# External Bus Controller Register File

This block is the register file that sits in front of a processor's external bus controller. It holds seven halfword slots: two bus control words, a wait-state word, a memory control word, and three refresh-timer words. Software sees them through a 32-bit port with four byte strobes. Each register comes out of reset with its own value. Each one returns only its defined bits when read. The refresh counter slot is reserved: it stores nothing and reads zero.

Writes that enable any byte of the upper halfword are protected. The upper halfword must carry the key 0xA55A, or the whole write is dropped and a one-cycle rejection pulse is raised. Only the low halfword of an accepted write is stored, byte by byte under the strobes.

A strap input tells the block whether its processor is the bus slave. That strap shows up as the top bit of the first bus control word whenever that word is read.

Top module: `extbus_ctl_regs`

## Requirements
- R1: After reset the reads return 0x03F0 at byte offset 0x0, 0x00FC at 0x2, 0xAAFF at 0x4, and 0x0000 at offsets 0x6, 0x8 and 0xC.
- R2: Reads apply a per-register mask to the stored value: 0x1FF7 at 0x0, 0x00FC at 0x2, none at 0x4, 0xFEFC at 0x6, 0x00F8 at 0x8 and 0x00FF at 0xC. Bits 31:16 of `rdata` are always zero.
- R3: Bit 15 of a read at offset 0x0 equals `slave_strap` in the cycle of the read, whatever value is stored there.
- R4: A write with any of `be[3:2]` set is stored only when `wdata[31:16]` equals 0xA55A. Otherwise no register changes.
- R5: A write rejected under R4 drives `key_err` high for exactly the one cycle after the write. A write that is accepted, or that carries the key, never raises it.
- R6: In an accepted write, `be[0]` updates register bits 7:0 from `wdata[7:0]`, and `be[1]` updates bits 15:8 from `wdata[15:8]`. A byte whose strobe is clear keeps its value.
- R7: An access with exactly one byte strobe set is treated as an 8-bit access and ignored. It changes no register and raises no `key_err`, even when the key is wrong.
- R8: The following are ignored for writes and read as zero: offset 0xE, the refresh counter slot at 0xA, and any odd byte offset.
- R9: `rdata` carries the result in the cycle after `rd_en` is sampled high, and is zero in the cycle after any clock edge where `rd_en` is low.
- R10: A write with both `be[3:2]` clear needs no key and is stored under R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slave_strap | input | 1 | High when the processor is the bus slave |
| wr_en | input | 1 | Write request for this cycle |
| rd_en | input | 1 | Read request for this cycle |
| addr | input | ADDR_W (4) | Byte offset inside the register window |
| be | input | DATA_W/8 (4) | Byte strobes for the write |
| wdata | input | DATA_W (32) | Write data; key in bits 31:16 |
| rdata | output | DATA_W (32) | Registered read data |
| key_err | output | 1 | One-cycle pulse for a write rejected on its key |

## Verification
The bench builds the block with its default parameters: a 32-bit port, a 4-bit byte offset and the key 0xA55A. With a 4-bit offset the window has eight slots, so every slot is in reach, including the unmapped one at 0xE and the reserved counter slot, and so is every odd offset. With four strobes the bench can form every strobe pattern that matters: lower-only, upper-only, mixed, and single-lane. That covers the key check, the byte merging and the 8-bit rejection against each other. The strap is toggled between reads of the first control word, so bit 15 is shown to follow the pin and not the stored data.

// File: rtl/xbc_pkg.sv
package xbc_pkg;

    localparam int unsigned REG_W = 16;

    typedef enum logic [2:0] {
        SL_BUSCTL_A  = 3'd0,
        SL_BUSWIDTH  = 3'd1,
        SL_WAITST    = 3'd2,
        SL_MEMCTL    = 3'd3,
        SL_RF_CTRL   = 3'd4,
        SL_RF_COUNT  = 3'd5,
        SL_RF_CONST  = 3'd6,
        SL_VOID      = 3'd7
    } slot_e;

    // Value each slot takes in reset
    function automatic logic [REG_W-1:0] slot_reset(input int idx);
        case (idx)
            int'(SL_BUSCTL_A): return 16'h03F0;
            int'(SL_BUSWIDTH): return 16'h00FC;
            int'(SL_WAITST):   return 16'hAAFF;
            default:           return 16'h0000;
        endcase
    endfunction

    // Bits a read reveals
    function automatic logic [REG_W-1:0] slot_mask(input int idx);
        case (idx)
            int'(SL_BUSCTL_A): return 16'h1FF7;
            int'(SL_BUSWIDTH): return 16'h00FC;
            int'(SL_WAITST):   return 16'hFFFF;
            int'(SL_MEMCTL):   return 16'hFEFC;
            int'(SL_RF_CTRL):  return 16'h00F8;
            int'(SL_RF_CONST): return 16'h00FF;
            default:           return 16'h0000;
        endcase
    endfunction

    // Slots that hold storage
    function automatic bit slot_stored(input int idx);
        case (idx)
            int'(SL_BUSCTL_A), int'(SL_BUSWIDTH), int'(SL_WAITST),
            int'(SL_MEMCTL), int'(SL_RF_CTRL), int'(SL_RF_CONST): return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Bit of the first control word that carries the strap
    localparam int unsigned STRAP_BIT = 15;

endpackage

// File: rtl/xbc_access_check.sv
module xbc_access_check #(
    parameter int unsigned DATA_W = 32,
    parameter logic [DATA_W/2-1:0] KEY = 16'hA55A
) (
    input  logic              wr_en,
    input  logic [DATA_W/8-1:0] be,
    input  logic [DATA_W-1:0] wdata,
    output logic              commit,
    output logic              bad_key
);
    localparam int unsigned BE_W   = DATA_W / 8;
    localparam int unsigned HALF_W = DATA_W / 2;
    localparam int unsigned LO_BE  = BE_W / 2;
    localparam int unsigned CNT_W  = $clog2(BE_W + 1);

    logic [CNT_W-1:0] lanes;
    logic             upper_on;
    logic             key_match;
    logic             wide_ok;

    always_comb begin
        lanes = '0;
        for (int k = 0; k < BE_W; k++) begin
            lanes = lanes + CNT_W'(be[k]);
        end
        upper_on  = |be[BE_W-1:LO_BE];
        key_match = (wdata[DATA_W-1:HALF_W] == KEY);
        // a single active lane is a byte access, which is not allowed
        wide_ok   = wr_en && (lanes >= CNT_W'(2));
        commit    = wide_ok && (!upper_on || key_match);
        bad_key   = wide_ok && upper_on && !key_match;
    end

endmodule

// File: rtl/xbc_reg_slot.sv
module xbc_reg_slot #(
    parameter int unsigned REG_W = 16,
    parameter logic [REG_W-1:0] RESET = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [REG_W/8-1:0] byte_we,
    input  logic [REG_W-1:0]   wd,
    output logic [REG_W-1:0]   q
);
    localparam int unsigned NBYTE = REG_W / 8;

    logic [REG_W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (we) begin
            for (int b = 0; b < NBYTE; b++) begin
                if (byte_we[b]) begin
                    val_d[b*8 +: 8] = wd[b*8 +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= RESET;
        end else begin
            val_q <= val_d;
        end
    end

    assign q = val_q;

endmodule

// File: rtl/xbc_read_port.sv
module xbc_read_port
    import xbc_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              slave_strap,
    input  logic [REG_W-1:0]  slot_val [2**(ADDR_W-1)],
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned SLOT_W = ADDR_W - 1;

    typedef struct packed {
        logic [DATA_W-1:0] data;
    } rd_state_t;

    rd_state_t        st_d, st_q;
    logic [SLOT_W-1:0] idx;
    logic [REG_W-1:0]  shown;

    always_comb begin
        idx   = addr[ADDR_W-1:1];
        shown = slot_val[idx] & slot_mask(int'(idx));
        if (idx == SLOT_W'(SL_BUSCTL_A)) begin
            shown[STRAP_BIT] = slave_strap;
        end
        st_d = '0;
        if (rd_en && !addr[0]) begin
            st_d.data = DATA_W'(shown);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.data;

endmodule

// File: rtl/extbus_ctl_regs.sv
module extbus_ctl_regs
    import xbc_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4,
    parameter logic [DATA_W/2-1:0] KEY = 16'hA55A
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                slave_strap,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W/8-1:0] be,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic                key_err
);
    localparam int unsigned SLOT_W = ADDR_W - 1;
    localparam int unsigned NSLOT  = 2 ** SLOT_W;
    localparam int unsigned RBYTES = REG_W / 8;

    typedef struct packed {
        logic key_err;
    } top_state_t;

    top_state_t        st_d, st_q;
    logic              commit;
    logic              bad_key;
    logic [SLOT_W-1:0] wr_idx;
    logic              aligned;
    logic [REG_W-1:0]  slot_val [NSLOT];

    xbc_access_check #(
        .DATA_W (DATA_W),
        .KEY    (KEY)
    ) u_check (
        .wr_en   (wr_en),
        .be      (be),
        .wdata   (wdata),
        .commit  (commit),
        .bad_key (bad_key)
    );

    assign wr_idx  = addr[ADDR_W-1:1];
    assign aligned = !addr[0];

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        localparam bit              HAS_STORE = slot_stored(i);
        localparam logic [REG_W-1:0] RST_VAL  = slot_reset(i);
        logic hit;
        assign hit = HAS_STORE && commit && aligned && (wr_idx == SLOT_W'(i));
        xbc_reg_slot #(
            .REG_W (REG_W),
            .RESET (RST_VAL)
        ) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (hit),
            .byte_we (be[RBYTES-1:0]),
            .wd      (wdata[REG_W-1:0]),
            .q       (slot_val[i])
        );
    end

    xbc_read_port #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_read (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en       (rd_en),
        .addr        (addr),
        .slave_strap (slave_strap),
        .slot_val    (slot_val),
        .rdata       (rdata)
    );

    always_comb begin
        st_d         = st_q;
        st_d.key_err = bad_key;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign key_err = st_q.key_err;

endmodule

// File: rtl/xbc_checker.sv
module xbc_checker #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4,
    parameter logic [DATA_W/2-1:0] KEY = 16'hA55A
) (
    input logic                clk,
    input logic                rst_n,
    input logic                slave_strap,
    input logic                wr_en,
    input logic                rd_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [DATA_W/8-1:0] be,
    input logic [DATA_W-1:0]   wdata,
    input logic [DATA_W-1:0]   rdata,
    input logic                key_err
);
    localparam int unsigned HALF_W = DATA_W / 2;
    localparam int unsigned BE_W   = DATA_W / 8;

    a_r5_err_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        key_err |-> $past(wr_en && ($countones(be) > 1) && (|be[BE_W-1:BE_W/2])
                          && (wdata[DATA_W-1:HALF_W] != KEY)));

    a_r5_good_key_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata[DATA_W-1:HALF_W] == KEY) |=> !key_err);

    a_r7_byte_access_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $countones(be) == 1) |=> !key_err);

    a_r3_strap_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == '0) |=> (rdata[15] == $past(slave_strap)));

    a_r2_upper_half_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DATA_W-1:HALF_W] == '0);

    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata == '0));

    a_r8_void_slot_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr[ADDR_W-1:1] == '1) |=> (rdata == '0));

endmodule

bind extbus_ctl_regs xbc_checker #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .KEY    (KEY)
) u_xbc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .slave_strap (slave_strap),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .be          (be),
    .wdata       (wdata),
    .rdata       (rdata),
    .key_err     (key_err)
);

// File: tb/extbus_ctl_regs_test.sv
module extbus_ctl_regs_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slave_strap = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [3:0]  be = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        key_err;

    int checks = 0;
    int fails  = 0;
    logic pend = 1'b0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    extbus_ctl_regs uut (
        .clk (clk), .rst_n (rst_n), .slave_strap (slave_strap),
        .wr_en (wr_en), .rd_en (rd_en), .addr (addr), .be (be),
        .wdata (wdata), .rdata (rdata), .key_err (key_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: a read sampled at a posedge is compared at the next negedge
    always @(posedge clk) pend <= rd_en;
    always @(negedge clk) begin
        if (pend && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, rdata, e);
        end
    end

    task automatic do_read(input logic [3:0] a, input logic [31:0] exp, input string req);
        addr  = a;
        rd_en = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(req);
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_write(input logic [3:0] a, input logic [3:0] strobes,
                            input logic [31:0] d, input logic exp_err, input string req);
        addr  = a;
        be    = strobes;
        wdata = d;
        wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        be    = '0;
        wdata = '0;
        check({req, " key_err"}, {31'b0, key_err}, {31'b0, exp_err});
        if (exp_err) begin
            @(posedge clk);
            @(negedge clk);
            check("R5 pulse width", {31'b0, key_err}, 32'h0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset key_err", {31'b0, key_err}, 32'h0);
        check("R9 reset rdata", rdata, 32'h0);

        // R1 reset values
        do_read(4'h0, 32'h0000_03F0, "R1 busctl_a");
        do_read(4'h2, 32'h0000_00FC, "R1 buswidth");
        do_read(4'h4, 32'h0000_AAFF, "R1 waitst");
        do_read(4'h6, 32'h0000_0000, "R1 memctl");
        do_read(4'h8, 32'h0000_0000, "R1 rf_ctrl");
        do_read(4'hC, 32'h0000_0000, "R1 rf_const");

        // R10 no key needed for lower-only write
        do_write(4'h4, 4'b0011, 32'h0000_1234, 1'b0, "R10");
        do_read(4'h4, 32'h0000_1234, "R10 readback");

        // R2 masks
        do_write(4'h0, 4'b0011, 32'h0000_FFFF, 1'b0, "R2");
        do_write(4'h2, 4'b0011, 32'h0000_FFFF, 1'b0, "R2");
        do_write(4'h6, 4'b0011, 32'h0000_FFFF, 1'b0, "R2");
        do_write(4'h8, 4'b0011, 32'h0000_FFFF, 1'b0, "R2");
        do_write(4'hC, 4'b0011, 32'h0000_FFFF, 1'b0, "R2");
        do_read(4'h0, 32'h0000_1FF7, "R2 busctl_a mask");
        do_read(4'h2, 32'h0000_00FC, "R2 buswidth mask");
        do_read(4'h6, 32'h0000_FEFC, "R2 memctl mask");
        do_read(4'h8, 32'h0000_00F8, "R2 rf_ctrl mask");
        do_read(4'hC, 32'h0000_00FF, "R2 rf_const mask");

        // R3 strap
        slave_strap = 1'b1;
        do_read(4'h0, 32'h0000_9FF7, "R3 strap high");
        slave_strap = 1'b0;
        do_read(4'h0, 32'h0000_1FF7, "R3 strap low");

        // R4 key protection
        do_write(4'h4, 4'b1111, 32'hA55A_5555, 1'b0, "R4 good key");
        do_read(4'h4, 32'h0000_5555, "R4 good key stored");
        do_write(4'h4, 4'b1111, 32'h1234_0000, 1'b1, "R4 R5 bad key");
        do_read(4'h4, 32'h0000_5555, "R4 bad key dropped");
        do_write(4'h4, 4'b1100, 32'hDEAD_0000, 1'b1, "R5 upper only bad");
        do_write(4'h4, 4'b1100, 32'hA55A_0000, 1'b0, "R4 upper only good");
        do_read(4'h4, 32'h0000_5555, "R4 upper only no change");

        // R6 byte lanes
        do_write(4'h4, 4'b0110, 32'hA55A_ABCD, 1'b0, "R6 high byte");
        do_read(4'h4, 32'h0000_AB55, "R6 high byte only");
        do_write(4'h4, 4'b1101, 32'hA55A_00EE, 1'b0, "R6 low byte");
        do_read(4'h4, 32'h0000_ABEE, "R6 low byte only");

        // R7 byte accesses ignored
        do_write(4'h4, 4'b0001, 32'h0000_0099, 1'b0, "R7 lone lane");
        do_write(4'h4, 4'b0100, 32'hBEEF_0000, 1'b0, "R7 lone upper lane");
        do_read(4'h4, 32'h0000_ABEE, "R7 unchanged");

        // R8 unmapped, counter slot and odd offsets
        do_write(4'hE, 4'b0011, 32'h0000_FFFF, 1'b0, "R8 void write");
        do_read(4'hE, 32'h0000_0000, "R8 void reads zero");
        do_write(4'hA, 4'b0011, 32'h0000_FFFF, 1'b0, "R8 counter write");
        do_read(4'hA, 32'h0000_0000, "R8 counter reads zero");
        do_write(4'h5, 4'b0011, 32'h0000_0000, 1'b0, "R8 odd write");
        do_read(4'h5, 32'h0000_0000, "R8 odd reads zero");
        do_read(4'h4, 32'h0000_ABEE, "R8 odd write ignored");

        // R9 idle output
        @(posedge clk);
        @(negedge clk);
        check("R9 idle rdata", rdata, 32'h0);

        repeat (2) @(posedge clk);
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule